// File: doc/BRIEF.md
# Digital Load-Line Droop Stage

This block sets the output-voltage load line of a multi-phase regulator in the digital domain. It keeps the most recent current reading of every phase. It averages those readings over the phases that are switched on, and it scales the average by a programmable slope. The scaled value is smoothed by a first-order low-pass filter with a shift-selected time constant. The smoothed droop term is then taken away from each incoming voltage-error word. The compensator therefore sees a target that sits lower as load current rises.

The phase currents arrive together as one wide word with a single strobe. The voltage-error word arrives as a signed value with its own strobe. The filter advances once for each error word. Each error word yields exactly one adjusted word two clock edges later, clamped to the signed output range.

Top module: `avp_loadline`

## Requirements
- R1: While `rst` is high at a rising edge, the stored phase currents, the filter state and the output register clear to zero and `adj_valid_o` goes low.
- R2: The average is `(S * round(65536 / n)) >> 16` (round half up, then floor). S is the sum of the stored currents of the phases whose `phase_en_i` bit is 1, and n is the number of 1 bits in `phase_en_i`.
- R3: When `phase_en_i` is all zero, the average is zero.
- R4: The filter input is `(average * gain_i) >> 4`, so `gain_i` is unsigned with four fraction bits (16 means a slope of 1.0).
- R5: On every edge where `err_valid_i` is high, the filter state `y` becomes `y + floor((x - y) / 2^shift_i)`, with `shift_i` from 0 to 7. A shift of 0 makes `y` equal to `x`.
- R6: On edges where `err_valid_i` is low, the filter state keeps its value.
- R7: The adjusted word is the error word minus the filter state produced by that same error sample.
- R8: The adjusted word is clamped to the signed range of `adj_o` and never wraps.
- R9: `adj_valid_o` is high for one cycle exactly two rising edges after each edge where `err_valid_i` is high. Back-to-back inputs give back-to-back outputs. `adj_o` holds its value between valid outputs.
- R10: Phase currents are stored only on edges where `cur_valid_i` is high. At other times `cur_i` is ignored, and the average is always taken from the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_valid_i | input | 1 | Strobe that stores all phase currents |
| cur_i | input | NPH*IW | Unsigned phase currents, phase p in bits [p*IW +: IW] |
| phase_en_i | input | NPH | Enabled-phase mask, bit p for phase p |
| gain_i | input | GW | Load-line slope, unsigned with 4 fraction bits |
| shift_i | input | 3 | Filter shift k (0 to 7) |
| err_valid_i | input | 1 | Voltage-error strobe |
| err_i | input | EW | Signed voltage-error word |
| adj_valid_o | output | 1 | Adjusted-error strobe |
| adj_o | output | OW | Signed adjusted error to the compensator |

## Verification
On every cycle, the assertions check the timing of the output strobe and several filter properties. The filter must hold when no error sample arrives, and it must land between its old value and its input when one does. A shift of zero must track the input exactly. An empty mask must give a zero average, and the output must never rise above the error word it came from. Only the bench's scenarios can show the exact averaging through the reciprocal table for uneven phase counts, the decay sequence for larger shifts, negative clamping under heavy load with a large slope, and that current words without their strobe have no effect. The bench shows these by comparing every cycle against a behavioural model.

// File: rtl/avp_pkg.sv
package avp_pkg;

    localparam int RECIP_SHIFT = 16;
    localparam int GAIN_FRAC   = 4;

    typedef logic [2:0] lpf_shift_t;

    function automatic int unsigned recip_of(input int unsigned n);
        if (n == 0) return 0;
        return ((32'd1 << RECIP_SHIFT) + n / 2) / n;
    endfunction

    function automatic int unsigned ones_in(input logic [31:0] v);
        int unsigned c;
        c = 0;
        for (int i = 0; i < 32; i++) c += int'(v[i]);
        return c;
    endfunction

endpackage

// File: rtl/avp_phase_avg.sv
module avp_phase_avg
    import avp_pkg::*;
#(
    parameter int NPH = 8,
    parameter int IW  = 12,
    parameter int AW  = IW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cur_valid_i,
    input  logic [NPH*IW-1:0] cur_i,
    input  logic [NPH-1:0]    phase_en_i,
    output logic [AW-1:0]     avg_o
);
    localparam int CW = $clog2(NPH + 1);
    localparam int SW = IW + CW;
    localparam int RW = RECIP_SHIFT + 1;
    localparam int PW = SW + RW;

    logic [IW-1:0] held   [NPH];
    logic [IW-1:0] masked [NPH];
    logic [RW-1:0] rtab   [NPH+1];
    logic [SW-1:0] sum;
    logic [CW-1:0] cnt;
    logic [RW-1:0] recip_sel;
    logic [PW-1:0] prod;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        always_ff @(posedge clk) begin
            if (rst)              held[p] <= '0;
            else if (cur_valid_i) held[p] <= cur_i[p*IW +: IW];
        end
        assign masked[p] = phase_en_i[p] ? held[p] : '0;
    end

    for (genvar g = 0; g <= NPH; g++) begin : g_recip
        assign rtab[g] = RW'(recip_of(g));
    end

    always_comb begin
        sum = '0;
        for (int p = 0; p < NPH; p++) sum = sum + SW'(masked[p]);
    end

    assign cnt       = CW'(ones_in(32'(phase_en_i)));
    assign recip_sel = rtab[cnt];
    assign prod      = PW'(sum) * PW'(recip_sel);
    assign avg_o     = AW'(prod >> RECIP_SHIFT);

endmodule

// File: rtl/avp_lpf.sv
module avp_lpf
    import avp_pkg::*;
#(
    parameter int AW = 13,
    parameter int GW = 8,
    parameter int XW = AW + GW - GAIN_FRAC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] avg_i,
    input  logic [GW-1:0] gain_i,
    input  lpf_shift_t    shift_i,
    input  logic          upd_i,
    output logic [XW-1:0] x_o,
    output logic [XW-1:0] y_o
);
    localparam int MW = AW + GW;

    logic [MW-1:0]        scaled;
    logic signed [XW:0]   diff;
    logic signed [XW:0]   step;
    logic signed [XW+1:0] nxt;

    assign scaled = MW'(avg_i) * MW'(gain_i);
    assign x_o    = XW'(scaled >> GAIN_FRAC);
    assign diff   = $signed({1'b0, x_o}) - $signed({1'b0, y_o});
    assign step   = diff >>> shift_i;
    assign nxt    = $signed({2'b00, y_o}) + $signed({step[XW], step});

    always_ff @(posedge clk) begin
        if (rst)        y_o <= '0;
        else if (upd_i) y_o <= XW'(nxt);
    end

endmodule

// File: rtl/avp_err_sub.sv
module avp_err_sub #(
    parameter int EW = 12,
    parameter int XW = 17,
    parameter int OW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 err_valid_i,
    input  logic signed [EW-1:0] err_i,
    input  logic [XW-1:0]        y_i,
    output logic                 adj_valid_o,
    output logic signed [OW-1:0] adj_o
);
    localparam int DW = ((EW > XW) ? EW : XW) + 2;
    localparam logic signed [DW-1:0] OMAX = DW'((64'sd1 <<< (OW - 1)) - 1);
    localparam logic signed [DW-1:0] OMIN = -DW'(64'sd1 <<< (OW - 1));

    logic                 v1;
    logic signed [EW-1:0] e1;
    logic signed [DW-1:0] diff;
    logic signed [OW-1:0] clamped;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            e1 <= '0;
        end else begin
            v1 <= err_valid_i;
            if (err_valid_i) e1 <= err_i;
        end
    end

    assign diff = $signed({{(DW-EW){e1[EW-1]}}, e1}) - $signed({{(DW-XW){1'b0}}, y_i});

    always_comb begin
        if (diff > OMAX)      clamped = OMAX[OW-1:0];
        else if (diff < OMIN) clamped = OMIN[OW-1:0];
        else                  clamped = diff[OW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            adj_valid_o <= 1'b0;
            adj_o       <= '0;
        end else begin
            adj_valid_o <= v1;
            if (v1) adj_o <= clamped;
        end
    end

endmodule

// File: rtl/avp_loadline.sv
module avp_loadline
    import avp_pkg::*;
#(
    parameter int NPH = 8,
    parameter int IW  = 12,
    parameter int GW  = 8,
    parameter int EW  = 12,
    parameter int OW  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cur_valid_i,
    input  logic [NPH*IW-1:0]    cur_i,
    input  logic [NPH-1:0]       phase_en_i,
    input  logic [GW-1:0]        gain_i,
    input  logic [2:0]           shift_i,
    input  logic                 err_valid_i,
    input  logic signed [EW-1:0] err_i,
    output logic                 adj_valid_o,
    output logic signed [OW-1:0] adj_o
);
    localparam int AW = IW + 1;
    localparam int XW = AW + GW - GAIN_FRAC;

    logic [AW-1:0] avg_w;
    logic [XW-1:0] x_w;
    logic [XW-1:0] y_w;

    avp_phase_avg #(.NPH(NPH), .IW(IW), .AW(AW)) u_avg (
        .clk         (clk),
        .rst         (rst),
        .cur_valid_i (cur_valid_i),
        .cur_i       (cur_i),
        .phase_en_i  (phase_en_i),
        .avg_o       (avg_w)
    );

    avp_lpf #(.AW(AW), .GW(GW), .XW(XW)) u_lpf (
        .clk     (clk),
        .rst     (rst),
        .avg_i   (avg_w),
        .gain_i  (gain_i),
        .shift_i (lpf_shift_t'(shift_i)),
        .upd_i   (err_valid_i),
        .x_o     (x_w),
        .y_o     (y_w)
    );

    avp_err_sub #(.EW(EW), .XW(XW), .OW(OW)) u_sub (
        .clk         (clk),
        .rst         (rst),
        .err_valid_i (err_valid_i),
        .err_i       (err_i),
        .y_i         (y_w),
        .adj_valid_o (adj_valid_o),
        .adj_o       (adj_o)
    );

endmodule

// File: rtl/avp_loadline_chk.sv
module avp_loadline_chk #(
    parameter int NPH = 8,
    parameter int EW  = 12,
    parameter int OW  = 12,
    parameter int AW  = 13,
    parameter int XW  = 17
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 err_valid_i,
    input logic signed [EW-1:0] err_i,
    input logic [NPH-1:0]       phase_en_i,
    input logic [2:0]           shift_i,
    input logic                 adj_valid_o,
    input logic signed [OW-1:0] adj_o,
    input logic [AW-1:0]        avg,
    input logic [XW-1:0]        x,
    input logic [XW-1:0]        y
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!adj_valid_o && adj_o == '0 && y == '0)); // R1

    AST_EMPTY_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase_en_i == '0) |-> (avg == '0)); // R3

    AST_SHIFT0_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (err_valid_i && shift_i == 3'd0) |=> (y == $past(x))); // R5

    AST_FILTER_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        err_valid_i |=> (($past(x) >= $past(y)) ? (y >= $past(y) && y <= $past(x))
                                               : (y <= $past(y) && y >= $past(x)))); // R5

    AST_FILTER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !err_valid_i |=> $stable(y)); // R6

    AST_DROOP_NOT_ABOVE: assert property (@(posedge clk) disable iff (rst)
        adj_valid_o |-> ($signed(adj_o) <= $signed($past(err_i, 2)))); // R7

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        err_valid_i |=> ##1 adj_valid_o); // R9

    AST_VALID_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        adj_valid_o |-> $past(err_valid_i, 2)); // R9

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !adj_valid_o |-> $stable(adj_o)); // R9
endmodule

bind avp_loadline avp_loadline_chk #(
    .NPH(NPH), .EW(EW), .OW(OW), .AW(AW), .XW(XW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .err_valid_i (err_valid_i),
    .err_i       (err_i),
    .phase_en_i  (phase_en_i),
    .shift_i     (shift_i),
    .adj_valid_o (adj_valid_o),
    .adj_o       (adj_o),
    .avg         (avg_w),
    .x           (x_w),
    .y           (y_w)
);

// File: tb/avp_loadline_test.sv
module avp_loadline_test;
    localparam int PERIOD = 10;
    localparam int NPH = 8;
    localparam int IW  = 12;
    localparam int GW  = 8;
    localparam int EW  = 12;
    localparam int OW  = 12;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 cur_valid_i;
    logic [NPH*IW-1:0]    cur_i;
    logic [NPH-1:0]       phase_en_i;
    logic [GW-1:0]        gain_i;
    logic [2:0]           shift_i;
    logic                 err_valid_i;
    logic signed [EW-1:0] err_i;
    logic                 adj_valid_o;
    logic signed [OW-1:0] adj_o;

    avp_loadline #(.NPH(NPH), .IW(IW), .GW(GW), .EW(EW), .OW(OW)) uut (
        .clk(clk), .rst(rst), .cur_valid_i(cur_valid_i), .cur_i(cur_i),
        .phase_en_i(phase_en_i), .gain_i(gain_i), .shift_i(shift_i),
        .err_valid_i(err_valid_i), .err_i(err_i),
        .adj_valid_o(adj_valid_o), .adj_o(adj_o)
    );

    always #(PERIOD/2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural model state
    longint m_held [NPH];
    longint m_y, m_e1, m_ao;
    bit     m_v1, m_vo;
    int     drv [NPH];

    function automatic longint clampo(input longint v);
        longint hi = (64'sd1 <<< (OW-1)) - 1;
        longint lo = -(64'sd1 <<< (OW-1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic model_eval();
        longint n, s, avg, xv, ny;
        if (rst) begin
            foreach (m_held[p]) m_held[p] = 0;
            m_y = 0; m_e1 = 0; m_ao = 0; m_v1 = 0; m_vo = 0;
        end else begin
            n = 0; s = 0;
            for (int p = 0; p < NPH; p++)
                if (phase_en_i[p]) begin n++; s += m_held[p]; end
            avg = (n == 0) ? 0 : (s * ((65536 + n/2) / n)) >>> 16;
            xv  = (avg * longint'(gain_i)) >>> 4;
            ny  = err_valid_i ? m_y + ((xv - m_y) >>> shift_i) : m_y;
            if (m_v1) m_ao = clampo(m_e1 - m_y);
            m_vo = m_v1;
            m_v1 = err_valid_i;
            if (err_valid_i) m_e1 = longint'(err_i);
            m_y = ny;
            if (cur_valid_i)
                for (int p = 0; p < NPH; p++) m_held[p] = longint'(drv[p]);
        end
    endtask

    task automatic compare();
        n_cmp++;
        if (adj_valid_o !== m_vo || longint'(adj_o) != m_ao) begin
            n_bad++;
            $display("FAIL %s t=%0t: valid=%0b adj=%0d expected valid=%0b adj=%0d",
                     cur_req, $time, adj_valid_o, adj_o, m_vo, m_ao);
        end
    endtask

    task automatic put_cur();
        for (int p = 0; p < NPH; p++) cur_i[p*IW +: IW] = IW'(drv[p]);
    endtask

    task automatic cyc();
        model_eval();
        @(negedge clk);
        compare();
    endtask

    task automatic err_pulse(input int e);
        err_valid_i = 1'b1; err_i = EW'(e);
        cyc();
        err_valid_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic load(input int base, input int stepv);
        for (int p = 0; p < NPH; p++) drv[p] = (base + p*stepv) % 4096;
        put_cur();
        cur_valid_i = 1'b1;
        cyc();
        cur_valid_i = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned lcg;
        rst = 1'b1; cur_valid_i = 1'b0; cur_i = '0; phase_en_i = '1;
        gain_i = 8'd16; shift_i = 3'd0; err_valid_i = 1'b0; err_i = '0;
        foreach (drv[p]) drv[p] = 0;

        // R1: reset state
        cur_req = "R1";
        idle(3);
        rst = 1'b0;
        idle(2);

        // R2 R4 R7 R9: all phases, unit slope, shift 0
        cur_req = "R2";
        load(100, 10);
        err_pulse(500);
        idle(3);
        cur_req = "R4";
        gain_i = 8'd40;
        err_pulse(-300);
        idle(3);
        cur_req = "R9";
        err_pulse(10); err_pulse(20); err_pulse(-30);
        idle(3);

        // R2: uneven phase counts through the reciprocal table
        cur_req = "R2";
        gain_i = 8'd16;
        load(1001, 333);
        for (int m = 1; m < 256; m += 37) begin
            phase_en_i = NPH'(m);
            err_pulse(m);
            idle(2);
        end

        // R3: empty mask
        cur_req = "R3";
        phase_en_i = '0;
        err_pulse(700);
        idle(3);

        // R5: decay with shifts 3 and 7
        cur_req = "R5";
        phase_en_i = '1;
        shift_i = 3'd3;
        for (int i = 0; i < 6; i++) err_pulse(0);
        idle(2);
        shift_i = 3'd7;
        phase_en_i = '0;
        for (int i = 0; i < 5; i++) err_pulse(100);
        idle(2);

        // R6: no error samples while load changes, filter holds
        cur_req = "R6";
        shift_i = 3'd0;
        phase_en_i = '1;
        load(3000, 50);
        idle(5);
        err_pulse(1);
        idle(3);

        // R10: current words without their strobe are ignored
        cur_req = "R10";
        for (int p = 0; p < NPH; p++) drv[p] = 5;
        put_cur();
        idle(2);
        err_pulse(0);
        idle(3);

        // R8: negative clamp under heavy load and steep slope
        cur_req = "R8";
        gain_i = 8'd255;
        load(4000, 10);
        err_pulse(-2000);
        err_pulse(2047);
        idle(3);
        gain_i = 8'd0;
        err_pulse(2047);
        err_pulse(-2048);
        idle(3);

        // R7: mixed stimulus
        cur_req = "R7";
        lcg = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            lcg = lcg * 1103515245 + 12345;
            phase_en_i  = NPH'(lcg >> 8);
            gain_i      = GW'(lcg >> 16);
            shift_i     = 3'(lcg >> 24);
            err_valid_i = lcg[27];
            err_i       = EW'(lcg >> 4);
            cur_valid_i = lcg[29];
            for (int p = 0; p < NPH; p++) drv[p] = int'((lcg >> p) & 12'hfff) ^ (p * 97);
            put_cur();
            cyc();
        end
        err_valid_i = 1'b0; cur_valid_i = 1'b0;
        idle(3);

        // R1: reset mid-stream
        cur_req = "R1";
        err_valid_i = 1'b1;
        rst = 1'b1;
        cyc();
        err_valid_i = 1'b0;
        cyc();
        rst = 1'b0;
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule